// File: doc/BRIEF.md
# Laptop Power State Controller

This block sequences a portable system through four power states: full operation (ON), idle with reduced activity (DOZE), suspended (SLEEP) and a state entered at software's request (APM). Inactivity timers count whole seconds and are restarted by activity strobes from the monitored system sources. Every state change raises a system-management interrupt request and sets a cause bit. The request stays high until software clears it. Two output pins follow the current state, and each pin has its own programmable level for every state.

The one-second tick comes from a prescaler that counts strobes of a 32.768 kHz enable input. A debounced active-low pushbutton suspends or resumes the system when its enable bit is set. When that bit is clear, the pin belongs to general-purpose I/O and this block ignores it. State transitions are: ON→DOZE on doze timeout; ON/DOZE→SLEEP on sleep timeout; DOZE/APM→ON on enabled activity; ON/DOZE/APM→SLEEP on a button press; SLEEP→ON on a button press; ON/DOZE→APM on an APM request; APM→SLEEP on the APM dwell timeout. The APM poll timeout raises an interrupt request but leaves the state in APM.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is ON, `smi_req` is low, `smi_cause` is zero and each pin shows its configured level for ON.
- R2: The state code is ON=0, DOZE=1, SLEEP=2, APM=3. Pin i drives `pin_cfg[4*i + state]`.
- R3: Each timer decrements once per second, and a second is PRESCALE strobes of `slow_en`. A timer with reload value N expires on the Nth tick after it is reloaded.
- R4: In ON, expiry of the doze timer moves the state to DOZE and sets cause bit 0.
- R5: The sleep timer runs in ON and DOZE. It is reloaded at the same moments as the doze timer, and its expiry moves the state to SLEEP with cause bit 1. When both timers expire on the same tick, SLEEP wins.
- R6: A strobe whose bit is set in `act_en` reloads both idle timers while the state is ON. In DOZE or APM it returns the state to ON and sets cause bit 2, and it reloads both idle timers. Masked strobes, and any strobe in SLEEP, change nothing.
- R7: The button is active low and must hold a new level for DEB_LEN consecutive `slow_en` strobes. A press moves ON, DOZE or APM to SLEEP, and moves SLEEP to ON. Either way it sets cause bit 3. With `sw_en` low the button has no effect.
- R8: An `apm_req` pulse in ON or DOZE enters APM and sets cause bit 4. In SLEEP or APM the pulse is ignored.
- R9: On entry to APM both APM timers are reloaded. Expiry of the dwell timer moves APM to SLEEP and sets cause bit 5.
- R10: Expiry of the poll timer in APM sets cause bit 6 and reloads that timer, and the state stays APM.
- R11: A timer whose reload value is zero never expires.
- R12: `smi_req` rises with every cause event and holds until a `smi_clr` pulse. Cause bits accumulate until the clear. If a clear and a new event arrive in the same cycle, the request stays high and only the new cause remains.
- R13: Priority within one cycle is button, then APM request, then activity, then timer expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| act_stb | input | N_ACT | Per-source activity strobes (six devices, six address groups) |
| act_en | input | N_ACT | Activity source enables |
| btn_n | input | 1 | Raw suspend/resume button, low when pressed |
| sw_en | input | 1 | Selects the button function of the switch pin |
| apm_req | input | 1 | Software request to enter APM (one-cycle pulse) |
| doze_rl | input | TW | Doze timeout in seconds, 0 disables |
| sleep_rl | input | TW | Sleep timeout in seconds, 0 disables |
| dwell_rl | input | TW | APM dwell timeout in seconds, 0 disables |
| poll_rl | input | TW | APM poll interval in seconds, 0 disables |
| smi_clr | input | 1 | Clears the request and the cause bits |
| pin_cfg | input | 4*NPIN | Per-state level of each output pin |
| state | output | 2 | Current state code |
| smi_req | output | 1 | Interrupt request level |
| smi_cause | output | 7 | Accumulated cause bits |
| pin_out | output | NPIN | State-dependent output pins |

## Verification
The hardest cases to reach are those where two things must land on exactly the same one-second tick. One is a timer expiring on the tick that shares a prescaler phase with the button debouncer. Another is a clear pulse arriving in the cycle of a new event. The bench keeps its own count of prescaler phase across every `slow_en` strobe, including the strobes spent debouncing. It can therefore count ticks exactly and check the state on both sides of each expiry tick. For the same-cycle case, it drives a wake-up activity strobe and `smi_clr` together in one cycle. Random reload values and pin configurations are then swept through repeated ON→DOZE→ON round trips.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        ST_ON    = 2'd0,
        ST_DOZE  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_APM   = 2'd3
    } pwr_state_e;

    localparam int CAUSE_W     = 7;
    localparam int C_DOZE_TO   = 0;
    localparam int C_SLEEP_TO  = 1;
    localparam int C_ACT_WAKE  = 2;
    localparam int C_BUTTON    = 3;
    localparam int C_APM_ENTER = 4;
    localparam int C_APM_DWELL = 5;
    localparam int C_APM_POLL  = 6;

endpackage

// File: rtl/pmc_prescale.sv
module pmc_prescale #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (slow_en) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + PW'(1);
        end
    end

    assign tick = slow_en && (cnt_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pmc_debounce.sv
module pmc_debounce #(
    parameter int DEB_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic btn_n,
    output logic press
);
    localparam int DW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DEB_LEN - 1);

    logic          sync1_q, sync2_q;
    logic          pressed_q;
    logic [DW-1:0] cnt_q;
    logic          raw_pressed;
    logic          mismatch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= btn_n;
            sync2_q <= sync1_q;
        end
    end

    assign raw_pressed = ~sync2_q;
    assign mismatch    = raw_pressed != pressed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pressed_q <= 1'b0;
        end else if (slow_en) begin
            if (!mismatch) begin
                cnt_q <= '0;
            end else if (cnt_q == DLAST) begin
                cnt_q     <= '0;
                pressed_q <= raw_pressed;
            end else begin
                cnt_q <= cnt_q + DW'(1);
            end
        end
    end

    assign press = slow_en && mismatch && (cnt_q == DLAST) && raw_pressed;

    // R7
    press_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> pressed_q);

endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
    parameter int TW       = 8,
    parameter bit PERIODIC = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] reload_val,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (PERIODIC && expire) begin
            cnt_q <= reload_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && (cnt_q > TW'(1))) |=> (cnt_q == $past(cnt_q) - TW'(1)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int NPIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_hit,
    input  logic               btn_press,
    input  logic               apm_req,
    input  logic               exp_doze,
    input  logic               exp_sleep,
    input  logic               exp_dwell,
    input  logic               exp_poll,
    input  logic               smi_clr,
    input  logic [4*NPIN-1:0]  pin_cfg,
    output pwr_state_e         state_o,
    output logic               rl_idle,
    output logic               rl_apm,
    output logic               smi_req,
    output logic [CAUSE_W-1:0] smi_cause,
    output logic [NPIN-1:0]    pin_out
);
    pwr_state_e         state_q, state_d;
    logic [CAUSE_W-1:0] evt;
    logic               evt_any;
    logic               first_q;
    logic               smi_q;
    logic [CAUSE_W-1:0] cause_q;

    // next-state and event selection: button > APM request > activity > timers
    always_comb begin
        state_d = state_q;
        evt     = '0;
        unique case (state_q)
            ST_ON: begin
                if (btn_press) begin
                    state_d = ST_SLEEP;  evt[C_BUTTON] = 1'b1;
                end else if (apm_req) begin
                    state_d = ST_APM;    evt[C_APM_ENTER] = 1'b1;
                end else if (act_hit) begin
                    state_d = ST_ON;
                end else if (exp_sleep) begin
                    state_d = ST_SLEEP;  evt[C_SLEEP_TO] = 1'b1;
                end else if (exp_doze) begin
                    state_d = ST_DOZE;   evt[C_DOZE_TO] = 1'b1;
                end
            end
            ST_DOZE: begin
                if (btn_press) begin
                    state_d = ST_SLEEP;  evt[C_BUTTON] = 1'b1;
                end else if (apm_req) begin
                    state_d = ST_APM;    evt[C_APM_ENTER] = 1'b1;
                end else if (act_hit) begin
                    state_d = ST_ON;     evt[C_ACT_WAKE] = 1'b1;
                end else if (exp_sleep) begin
                    state_d = ST_SLEEP;  evt[C_SLEEP_TO] = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (btn_press) begin
                    state_d = ST_ON;     evt[C_BUTTON] = 1'b1;
                end
            end
            ST_APM: begin
                if (btn_press) begin
                    state_d = ST_SLEEP;  evt[C_BUTTON] = 1'b1;
                end else if (act_hit) begin
                    state_d = ST_ON;     evt[C_ACT_WAKE] = 1'b1;
                end else if (exp_dwell) begin
                    state_d = ST_SLEEP;  evt[C_APM_DWELL] = 1'b1;
                end else if (exp_poll) begin
                    state_d = ST_APM;    evt[C_APM_POLL] = 1'b1;
                end
            end
        endcase
    end

    assign evt_any = |evt;
    assign rl_idle = first_q || ((state_d == ST_ON) && ((state_q != ST_ON) || act_hit));
    assign rl_apm  = (state_d == ST_APM) && (state_q != ST_APM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            first_q <= 1'b0;
        end
    end

    // interrupt request and cause: a new event wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_q   <= 1'b0;
            cause_q <= '0;
        end else if (evt_any) begin
            smi_q   <= 1'b1;
            cause_q <= (smi_clr ? '0 : cause_q) | evt;
        end else if (smi_clr) begin
            smi_q   <= 1'b0;
            cause_q <= '0;
        end
    end

    // outputs
    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            unique case (state_q)
                ST_ON:    pin_out[i] = pin_cfg[4*i + 0];
                ST_DOZE:  pin_out[i] = pin_cfg[4*i + 1];
                ST_SLEEP: pin_out[i] = pin_cfg[4*i + 2];
                ST_APM:   pin_out[i] = pin_cfg[4*i + 3];
            endcase
        end
    end

    assign state_o   = state_q;
    assign smi_req   = smi_q;
    assign smi_cause = cause_q;

    // R12
    smi_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> smi_q);

    // R12
    smi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smi_clr) && !$past(evt_any)) |-> (!smi_q && (cause_q == '0)));

    // R7
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_SLEEP) && (state_q != ST_SLEEP)) |->
            ((state_q == ST_ON) && $past(btn_press)));

    // R4
    doze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DOZE) && ($past(state_q) != ST_DOZE)) |->
            (($past(state_q) == ST_ON) && $past(exp_doze)));

    // R10
    poll_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_APM) && $past(exp_poll) &&
         !$past(btn_press || act_hit || exp_dwell)) |->
            ((state_q == ST_APM) && cause_q[C_APM_POLL]));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pmc_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int DEB_LEN  = 32,
    parameter int TW       = 8,
    parameter int N_ACT    = 12,
    parameter int NPIN     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_en,
    input  logic [N_ACT-1:0]   act_stb,
    input  logic [N_ACT-1:0]   act_en,
    input  logic               btn_n,
    input  logic               sw_en,
    input  logic               apm_req,
    input  logic [TW-1:0]      doze_rl,
    input  logic [TW-1:0]      sleep_rl,
    input  logic [TW-1:0]      dwell_rl,
    input  logic [TW-1:0]      poll_rl,
    input  logic               smi_clr,
    input  logic [4*NPIN-1:0]  pin_cfg,
    output logic [1:0]         state,
    output logic               smi_req,
    output logic [CAUSE_W-1:0] smi_cause,
    output logic [NPIN-1:0]    pin_out
);
    logic       tick;
    logic       raw_press, btn_press;
    logic       act_hit;
    logic       rl_idle, rl_apm;
    logic       exp_doze, exp_sleep, exp_dwell, exp_poll;
    pwr_state_e st;

    pmc_prescale #(.PRESCALE(PRESCALE)) u_prescale (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .tick(tick)
    );

    pmc_debounce #(.DEB_LEN(DEB_LEN)) u_debounce (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .btn_n(btn_n), .press(raw_press)
    );

    assign btn_press = raw_press && sw_en;
    assign act_hit   = |(act_stb & act_en);

    pmc_timer #(.TW(TW), .PERIODIC(1'b0)) u_doze_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(st == ST_ON),
        .load(rl_idle), .reload_val(doze_rl), .expire(exp_doze)
    );

    pmc_timer #(.TW(TW), .PERIODIC(1'b0)) u_sleep_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run((st == ST_ON) || (st == ST_DOZE)),
        .load(rl_idle), .reload_val(sleep_rl), .expire(exp_sleep)
    );

    pmc_timer #(.TW(TW), .PERIODIC(1'b0)) u_dwell_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(st == ST_APM),
        .load(rl_apm), .reload_val(dwell_rl), .expire(exp_dwell)
    );

    pmc_timer #(.TW(TW), .PERIODIC(1'b1)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(st == ST_APM),
        .load(rl_apm), .reload_val(poll_rl), .expire(exp_poll)
    );

    pmc_fsm #(.NPIN(NPIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .act_hit(act_hit), .btn_press(btn_press),
        .apm_req(apm_req), .exp_doze(exp_doze), .exp_sleep(exp_sleep),
        .exp_dwell(exp_dwell), .exp_poll(exp_poll), .smi_clr(smi_clr),
        .pin_cfg(pin_cfg), .state_o(st), .rl_idle(rl_idle), .rl_apm(rl_apm),
        .smi_req(smi_req), .smi_cause(smi_cause), .pin_out(pin_out)
    );

    assign state = st;

endmodule

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
    localparam int PRESCALE = 2;
    localparam int DEB_LEN  = 3;
    localparam int TW       = 6;
    localparam int N_ACT    = 12;
    localparam int NPIN     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slow_en = 1'b0;
    logic [N_ACT-1:0] act_stb = '0;
    logic [N_ACT-1:0] act_en = '1;
    logic             btn_n = 1'b1;
    logic             sw_en = 1'b1;
    logic             apm_req = 1'b0;
    logic [TW-1:0]    doze_rl = 6'd3, sleep_rl = '0, dwell_rl = '0, poll_rl = '0;
    logic             smi_clr = 1'b0;
    logic [7:0]       pin_cfg = 8'hA5;
    logic [1:0]       state;
    logic             smi_req;
    logic [6:0]       smi_cause;
    logic [NPIN-1:0]  pin_out;

    int vectors = 0;
    int fails = 0;
    int phase = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_state_ctrl #(.PRESCALE(PRESCALE), .DEB_LEN(DEB_LEN), .TW(TW),
                     .N_ACT(N_ACT), .NPIN(NPIN)) u_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .act_stb(act_stb), .act_en(act_en),
        .btn_n(btn_n), .sw_en(sw_en), .apm_req(apm_req), .doze_rl(doze_rl),
        .sleep_rl(sleep_rl), .dwell_rl(dwell_rl), .poll_rl(poll_rl), .smi_clr(smi_clr),
        .pin_cfg(pin_cfg), .state(state), .smi_req(smi_req), .smi_cause(smi_cause),
        .pin_out(pin_out)
    );

    function automatic logic [1:0] pin_exp(logic [7:0] cfg, logic [1:0] st);
        return {cfg[4 + st], cfg[st]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) slow_en = 1'b1;
        @(negedge clk) slow_en = 1'b0;
        phase = (phase + 1) % PRESCALE;
    endtask

    task automatic sec();
        do strobe(); while (phase != 0);
    endtask

    task automatic act_pulse(int idx);
        @(negedge clk) act_stb = N_ACT'(1) << idx;
        @(negedge clk) act_stb = '0;
    endtask

    task automatic clr_pulse();
        @(negedge clk) smi_clr = 1'b1;
        @(negedge clk) smi_clr = 1'b0;
    endtask

    task automatic apm_pulse();
        @(negedge clk) apm_req = 1'b1;
        @(negedge clk) apm_req = 1'b0;
    endtask

    task automatic btn_level(logic lvl);
        @(negedge clk) btn_n = lvl;
        repeat (3) @(negedge clk);
        repeat (DEB_LEN) strobe();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 smi", smi_req, 0);
        chk("R1 cause", smi_cause, 0);
        chk("R1 pins", pin_out, pin_exp(pin_cfg, 2'd0));

        // R3 R4 doze after exactly 3 ticks
        sec(); sec();
        chk("R3 before expiry", state, 0);
        sec();
        chk("R4 doze state", state, 1);
        chk("R4 cause", smi_cause, 7'h01);
        chk("R2 doze pins", pin_out, pin_exp(pin_cfg, 2'd1));
        clr_pulse();
        chk("R12 clear req", smi_req, 0);
        chk("R12 clear cause", smi_cause, 0);

        // R6 masked strobe ignored, then R12 clear collides with wake
        act_en = 12'h020;
        act_pulse(3);
        chk("R6 masked stays", state, 1);
        chk("R6 masked no smi", smi_req, 0);
        @(negedge clk) begin act_stb = 12'h020; smi_clr = 1'b1; end
        @(negedge clk) begin act_stb = '0; smi_clr = 1'b0; end
        chk("R6 wake", state, 0);
        chk("R12 set wins", smi_req, 1);
        chk("R12 only new cause", smi_cause, 7'h04);
        act_en = '1;
        clr_pulse();

        // R6 activity in ON reloads the doze timer
        sec(); sec();
        act_pulse(7);
        sec(); sec();
        chk("R6 reload held ON", state, 0);
        sec();
        chk("R6 doze after reload", state, 1);
        clr_pulse();
        act_pulse(0);
        clr_pulse();

        // R5 sleep timer in DOZE
        doze_rl = 6'd2; sleep_rl = 6'd5;
        act_pulse(1);
        sec(); sec();
        chk("R5 doze first", state, 1);
        clr_pulse();
        sec(); sec();
        chk("R5 before sleep", state, 1);
        sec();
        chk("R5 sleep state", state, 2);
        chk("R5 cause", smi_cause, 7'h02);
        chk("R2 sleep pins", pin_out, pin_exp(pin_cfg, 2'd2));
        clr_pulse();
        act_pulse(4);
        chk("R6 sleep ignores activity", state, 2);
        chk("R6 sleep no smi", smi_req, 0);
        apm_pulse();
        chk("R8 sleep ignores apm", state, 2);

        // R7 button disabled
        sw_en = 1'b0;
        btn_level(1'b0); btn_level(1'b1);
        chk("R7 disabled", state, 2);
        chk("R7 disabled smi", smi_req, 0);
        sw_en = 1'b1;

        // R7 resume from SLEEP
        doze_rl = 0; sleep_rl = 0;
        btn_level(1'b0);
        chk("R7 resume", state, 0);
        chk("R7 resume cause", smi_cause, 7'h08);
        btn_level(1'b1);
        clr_pulse();

        // R11 zero reload disables
        repeat (10) sec();
        chk("R11 stays ON", state, 0);
        chk("R11 no smi", smi_req, 0);

        // R7 suspend from ON
        btn_level(1'b0);
        chk("R7 suspend", state, 2);
        btn_level(1'b1);
        btn_level(1'b0);
        btn_level(1'b1);
        clr_pulse();

        // R8 R9 R10 APM
        dwell_rl = 6'd5; poll_rl = 6'd2;
        apm_pulse();
        chk("R8 apm state", state, 3);
        chk("R8 cause", smi_cause, 7'h10);
        chk("R2 apm pins", pin_out, pin_exp(pin_cfg, 2'd3));
        clr_pulse();
        sec();
        chk("R10 no poll yet", smi_req, 0);
        sec();
        chk("R10 poll stays", state, 3);
        chk("R10 poll cause", smi_cause, 7'h40);
        clr_pulse();
        sec(); sec();
        chk("R10 poll again", smi_cause, 7'h40);
        clr_pulse();
        sec();
        chk("R9 dwell sleep", state, 2);
        chk("R9 cause", smi_cause, 7'h20);
        btn_level(1'b0); btn_level(1'b1);
        clr_pulse();
        apm_pulse();
        clr_pulse();
        act_pulse(11);
        chk("R6 apm wake", state, 0);
        chk("R6 apm wake cause", smi_cause, 7'h04);
        clr_pulse();

        // R13 button beats activity in DOZE
        doze_rl = 6'd1;
        act_pulse(2);
        sec();
        chk("R13 doze setup", state, 1);
        clr_pulse();
        @(negedge clk) btn_n = 1'b0;
        repeat (3) @(negedge clk);
        repeat (DEB_LEN - 1) strobe();
        @(negedge clk) begin slow_en = 1'b1; act_stb = 12'h001; end
        @(negedge clk) begin slow_en = 1'b0; act_stb = '0; end
        phase = (phase + 1) % PRESCALE;
        chk("R13 button wins", state, 2);
        chk("R13 cause", smi_cause, 7'h08);
        btn_level(1'b1);
        doze_rl = 0;
        btn_level(1'b0); btn_level(1'b1);
        clr_pulse();

        // R2 R3 R4 random timeouts and pin levels
        for (int it = 0; it < 16; it++) begin
            int n;
            n = 1 + int'($urandom % 6);
            pin_cfg = 8'($urandom);
            doze_rl = TW'(n); sleep_rl = 0;
            act_pulse(int'($urandom % N_ACT));
            chk("R2 random ON pins", pin_out, pin_exp(pin_cfg, 2'd0));
            repeat (n - 1) sec();
            chk("R3 random before", state, 0);
            sec();
            chk("R4 random doze", state, 1);
            chk("R2 random DOZE pins", pin_out, pin_exp(pin_cfg, 2'd1));
            clr_pulse();
            doze_rl = 0;
            act_pulse(int'($urandom % N_ACT));
            clr_pulse();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule